// File: doc/BRIEF.md
# Audio sample FIFO with thresholds

This block sits between a register-strobe or DMA bus and a serial audio port. It buffers 16-bit samples in two directions. The transmit queue is filled by bus writes and drained by the serial side. The receive queue is filled by the serial side and drained by bus reads. Each queue reports its occupancy and four level flags, and raises a DMA request based on a programmable threshold.

Two error conditions are latched: starvation (a pop from an empty queue) and overflow (a push into a full queue). These two sticky bits and the four level flags form six interrupt sources per direction. Each source has its own enable, and a global enable gates them all. The enabled sources merge into one pending bit, which a clear strobe acknowledges. The transmit side sends all-zero data on underrun. The receive side drops a sample that arrives while the queue is full.

Top module: `audio_sample_queue`

## Requirements
- R1: A bus transmit write with bit 16 of `bus_tx_wdata` set stores bits 15:0 and raises `tx_count` by one. A write with bit 16 clear leaves the queue unchanged.
- R2: Each `ser_tx_pull` delivers the oldest stored transmit sample on `ser_tx_data`, with `ser_tx_valid` high, on the following cycle, and lowers `tx_count` by one.
- R3: A `ser_rx_push` stores `ser_rx_data`. Each `bus_rx_rd` returns the oldest sample on `bus_rx_rdata`, with bit 16 set, on the following cycle. A read from an empty queue returns all zeros and sets receive starvation.
- R4: No queue moves data unless both `ctl_enable` and that queue's own enable are high. Strobes given at other times change neither count.
- R5: Counts range from 0 to 32 (default depth). The level flags are: empty when count is 0, almost-empty when count ≤ 4, full when count is 32, and almost-full when count ≥ 28.
- R6: `tx_dma_req` is high exactly when transmit DMA is enabled, the transmit queue is active, and `tx_count` < `tx_thresh`.
- R7: `rx_dma_req` is high exactly when receive DMA is enabled, the receive queue is active, and `rx_count` ≥ `rx_thresh`.
- R8: A transmit pull from an empty queue drives `ser_tx_data` to zero and `ser_tx_valid` low, and sets the sticky transmit starvation bit.
- R9: A receive push into a full queue is dropped, the stored samples are kept, and the sticky receive overflow bit is set. A valid bus write into a full transmit queue sets the transmit overflow bit in the same way.
- R10: `irq_status` holds the sources. Receive sources are in bits 5:0 and transmit sources in bits 11:6. Within each direction the offsets are 0 empty, 1 almost-empty, 2 full, 3 almost-full, 4 starvation, 5 overflow. `irq_pending` sets on the clock edge after any source is high with its `irq_src_en` bit and `irq_global_en` both set. It stays low when the source is masked.
- R11: An `irq_clr` strobe clears `irq_pending` and both sticky error bits of each direction on that edge. If an enabled level source is still active, pending sets again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Controller-wide enable |
| tx_queue_en | input | 1 | Transmit queue enable |
| rx_queue_en | input | 1 | Receive queue enable |
| tx_dma_en | input | 1 | Transmit DMA handshake enable |
| rx_dma_en | input | 1 | Receive DMA handshake enable |
| tx_thresh | input | 6 | Transmit DMA threshold |
| rx_thresh | input | 6 | Receive DMA threshold |
| irq_global_en | input | 1 | Global interrupt enable |
| irq_src_en | input | 12 | Per-source interrupt enables, same layout as irq_status |
| irq_clr | input | 1 | Interrupt clear strobe |
| bus_tx_wr | input | 1 | Bus write strobe to transmit queue |
| bus_tx_wdata | input | 17 | Sample in 15:0, valid flag in 16 |
| bus_rx_rd | input | 1 | Bus read strobe from receive queue |
| bus_rx_rdata | output | 17 | Read sample in 15:0, valid flag in 16 |
| ser_tx_pull | input | 1 | Serial side requests a transmit sample |
| ser_tx_data | output | 16 | Transmit sample to serial side |
| ser_tx_valid | output | 1 | Transmit sample was stored data, not underrun filler |
| ser_rx_push | input | 1 | Serial side delivers a receive sample |
| ser_rx_data | input | 16 | Receive sample from serial side |
| tx_count | output | 6 | Transmit occupancy |
| rx_count | output | 6 | Receive occupancy |
| irq_status | output | 12 | Raw interrupt sources |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq_pending | output | 1 | Summary interrupt pending |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 32 entries, and level marks of 4 and 28. At this size a queue can be filled to the brim and pushed past it within a few dozen strobes, so both overflow paths and the full/almost-full edges are reached quickly. The default thresholds of 4 and 32 put the transmit request edge between counts 3 and 4. They also place the receive request edge at full depth, so the equal-to-threshold case of each comparison is observed directly.

// File: rtl/aq_pkg.sv
package aq_pkg;
  localparam int SRC_PER_DIR = 6;
  localparam int LVL_PER_DIR = 4;
  localparam int DIR_RX      = 0;
  localparam int DIR_TX      = 1;

  typedef enum int unsigned {
    SRC_EMPTY  = 0,
    SRC_AEMPTY = 1,
    SRC_FULL   = 2,
    SRC_AFULL  = 3,
    SRC_STARVE = 4,
    SRC_OVF    = 5
  } src_idx_e;

  function automatic int src_bit(input int dir, input src_idx_e s);
    return dir * SRC_PER_DIR + int'(s);
  endfunction
endpackage

// File: rtl/aq_queue.sv
module aq_queue #(
  parameter int WIDTH  = 16,
  parameter int DEPTH  = 32,
  parameter int AE_LVL = 4,
  parameter int AF_LVL = 28,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] pop_data,
  output logic             pop_hit,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             aempty,
  output logic             full,
  output logic             afull,
  output logic             starve_evt,
  output logic             ovf_evt
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [WIDTH-1:0] rd_raw;
  logic             push_ok, pop_ok;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign aempty = (count <= CNT_W'(AE_LVL));
  assign afull  = (count >= CNT_W'(AF_LVL));

  assign push_ok    = active && push_req && !full;
  assign pop_ok     = active && pop_req && !empty;
  assign starve_evt = active && pop_req && empty;
  assign ovf_evt    = active && push_req && full;

  // storage: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
    if (pop_ok)  rd_raw    <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      pop_hit <= 1'b0;
    end else begin
      if (push_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop_req) pop_hit <= pop_ok;
    end
  end

  assign pop_data = pop_hit ? rd_raw : '0;
endmodule

// File: rtl/aq_irq.sv
module aq_irq
  import aq_pkg::*;
#(
  parameter int DIRS = 2,
  localparam int SRC_W = DIRS * SRC_PER_DIR
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [DIRS-1:0][LVL_PER_DIR-1:0]  lvl,
  input  logic [DIRS-1:0]                   starve_evt,
  input  logic [DIRS-1:0]                   ovf_evt,
  input  logic [SRC_W-1:0]                  src_en,
  input  logic                              glb_en,
  input  logic                              clr,
  output logic [SRC_W-1:0]                  status,
  output logic                              pending
);
  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    logic starve_q, ovf_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        starve_q <= 1'b0;
        ovf_q    <= 1'b0;
      end else begin
        starve_q <= (starve_q && !clr) || starve_evt[d];
        ovf_q    <= (ovf_q && !clr) || ovf_evt[d];
      end
    end
    assign status[d*SRC_PER_DIR +: LVL_PER_DIR]        = lvl[d];
    assign status[d*SRC_PER_DIR + int'(SRC_STARVE)]    = starve_q;
    assign status[d*SRC_PER_DIR + int'(SRC_OVF)]       = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pending <= 1'b0;
    else            pending <= pending || (glb_en && |(status & src_en));
  end
endmodule

// File: rtl/audio_sample_queue.sv
module audio_sample_queue
  import aq_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 32,
  parameter int AE_LVL   = 4,
  parameter int AF_LVL   = 28,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int SRC_W   = 2 * SRC_PER_DIR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_enable,
  input  logic                tx_queue_en,
  input  logic                rx_queue_en,
  input  logic                tx_dma_en,
  input  logic                rx_dma_en,
  input  logic [CNT_W-1:0]    tx_thresh,
  input  logic [CNT_W-1:0]    rx_thresh,
  input  logic                irq_global_en,
  input  logic [SRC_W-1:0]    irq_src_en,
  input  logic                irq_clr,
  input  logic                bus_tx_wr,
  input  logic [SAMPLE_W:0]   bus_tx_wdata,
  input  logic                bus_rx_rd,
  output logic [SAMPLE_W:0]   bus_rx_rdata,
  input  logic                ser_tx_pull,
  output logic [SAMPLE_W-1:0] ser_tx_data,
  output logic                ser_tx_valid,
  input  logic                ser_rx_push,
  input  logic [SAMPLE_W-1:0] ser_rx_data,
  output logic [CNT_W-1:0]    tx_count,
  output logic [CNT_W-1:0]    rx_count,
  output logic [SRC_W-1:0]    irq_status,
  output logic                tx_dma_req,
  output logic                rx_dma_req,
  output logic                irq_pending
);
  logic tx_active, rx_active;
  logic tx_empty, tx_aempty, tx_full, tx_afull, tx_starve, tx_ovf;
  logic rx_empty, rx_aempty, rx_full, rx_afull, rx_starve, rx_ovf;
  logic [SAMPLE_W-1:0] rx_pop_data;
  logic                rx_pop_hit;

  assign tx_active = ctl_enable && tx_queue_en;
  assign rx_active = ctl_enable && rx_queue_en;

  aq_queue #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)) tx_q_i (
    .clk(clk), .rst(rst), .active(tx_active),
    .push_req(bus_tx_wr && bus_tx_wdata[SAMPLE_W]),
    .push_data(bus_tx_wdata[SAMPLE_W-1:0]),
    .pop_req(ser_tx_pull), .pop_data(ser_tx_data), .pop_hit(ser_tx_valid),
    .count(tx_count), .empty(tx_empty), .aempty(tx_aempty),
    .full(tx_full), .afull(tx_afull),
    .starve_evt(tx_starve), .ovf_evt(tx_ovf)
  );

  aq_queue #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)) rx_q_i (
    .clk(clk), .rst(rst), .active(rx_active),
    .push_req(ser_rx_push), .push_data(ser_rx_data),
    .pop_req(bus_rx_rd), .pop_data(rx_pop_data), .pop_hit(rx_pop_hit),
    .count(rx_count), .empty(rx_empty), .aempty(rx_aempty),
    .full(rx_full), .afull(rx_afull),
    .starve_evt(rx_starve), .ovf_evt(rx_ovf)
  );

  assign bus_rx_rdata = {rx_pop_hit, rx_pop_data};

  assign tx_dma_req = tx_dma_en && tx_active && (tx_count < tx_thresh);
  assign rx_dma_req = rx_dma_en && rx_active && (rx_count >= rx_thresh);

  aq_irq #(.DIRS(2)) irq_i (
    .clk(clk), .rst(rst),
    .lvl({{tx_afull, tx_full, tx_aempty, tx_empty},
          {rx_afull, rx_full, rx_aempty, rx_empty}}),
    .starve_evt({tx_starve, rx_starve}),
    .ovf_evt({tx_ovf, rx_ovf}),
    .src_en(irq_src_en), .glb_en(irq_global_en), .clr(irq_clr),
    .status(irq_status), .pending(irq_pending)
  );
endmodule

// File: rtl/aq_checker.sv
module aq_checker
  import aq_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 32,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int SRC_W   = 2 * SRC_PER_DIR
) (
  input logic                clk,
  input logic                rst,
  input logic                ctl_enable,
  input logic                tx_queue_en,
  input logic                rx_queue_en,
  input logic [CNT_W-1:0]    tx_thresh,
  input logic [CNT_W-1:0]    rx_thresh,
  input logic                irq_clr,
  input logic                bus_rx_rd,
  input logic                ser_tx_pull,
  input logic [SAMPLE_W-1:0] ser_tx_data,
  input logic                ser_rx_push,
  input logic [CNT_W-1:0]    tx_count,
  input logic [CNT_W-1:0]    rx_count,
  input logic [SRC_W-1:0]    irq_status,
  input logic                tx_dma_req,
  input logic                rx_dma_req,
  input logic                irq_pending
);
  p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_count) <= DEPTH) && (int'(rx_count) <= DEPTH));

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_count) == int'($past(tx_count))) ||
    (int'(tx_count) == int'($past(tx_count)) + 1) ||
    (int'(tx_count) == int'($past(tx_count)) - 1));

  p_halt_r4: assert property (@(posedge clk) disable iff (rst)
    !ctl_enable |=> ($stable(tx_count) && $stable(rx_count)));

  p_underrun_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (ser_tx_pull && ctl_enable && tx_queue_en && tx_count == '0)
      |=> (ser_tx_data == '0 && irq_status[src_bit(DIR_TX, SRC_STARVE)]));

  p_drop_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (ser_rx_push && !bus_rx_rd && ctl_enable && rx_queue_en && int'(rx_count) == DEPTH)
      |=> (int'(rx_count) == DEPTH && irq_status[src_bit(DIR_RX, SRC_OVF)]));

  p_tx_dma_r6: assert property (@(posedge clk) disable iff (rst)
    tx_dma_req |-> (tx_count < tx_thresh));

  p_rx_dma_r7: assert property (@(posedge clk) disable iff (rst)
    rx_dma_req |-> (rx_count >= rx_thresh));

  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> !irq_pending);
endmodule

bind audio_sample_queue aq_checker #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .tx_queue_en(tx_queue_en),
  .rx_queue_en(rx_queue_en), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
  .irq_clr(irq_clr), .bus_rx_rd(bus_rx_rd), .ser_tx_pull(ser_tx_pull),
  .ser_tx_data(ser_tx_data), .ser_rx_push(ser_rx_push), .tx_count(tx_count),
  .rx_count(rx_count), .irq_status(irq_status), .tx_dma_req(tx_dma_req),
  .rx_dma_req(rx_dma_req), .irq_pending(irq_pending)
);

// File: tb/audio_sample_queue_tb_top.sv
`timescale 1ns/1ps
module audio_sample_queue_tb_top;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_enable, tx_queue_en, rx_queue_en, tx_dma_en, rx_dma_en;
  logic [5:0]  tx_thresh, rx_thresh;
  logic        irq_global_en, irq_clr;
  logic [11:0] irq_src_en;
  logic        bus_tx_wr, bus_rx_rd, ser_tx_pull, ser_rx_push;
  logic [16:0] bus_tx_wdata, bus_rx_rdata;
  logic [15:0] ser_tx_data, ser_rx_data;
  logic        ser_tx_valid;
  logic [5:0]  tx_count, rx_count;
  logic [11:0] irq_status;
  logic        tx_dma_req, rx_dma_req, irq_pending;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  audio_sample_queue dut_i (
    .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .tx_queue_en(tx_queue_en),
    .rx_queue_en(rx_queue_en), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .irq_global_en(irq_global_en),
    .irq_src_en(irq_src_en), .irq_clr(irq_clr), .bus_tx_wr(bus_tx_wr),
    .bus_tx_wdata(bus_tx_wdata), .bus_rx_rd(bus_rx_rd), .bus_rx_rdata(bus_rx_rdata),
    .ser_tx_pull(ser_tx_pull), .ser_tx_data(ser_tx_data), .ser_tx_valid(ser_tx_valid),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .tx_count(tx_count),
    .rx_count(rx_count), .irq_status(irq_status), .tx_dma_req(tx_dma_req),
    .rx_dma_req(rx_dma_req), .irq_pending(irq_pending)
  );

  // op codes: 0 tx write valid, 1 tx write without valid, 2 serial pull,
  // 3 serial push, 4 bus read
  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] data;
    logic [5:0]  txc;
    logic [5:0]  rxc;
    logic [16:0] exp;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{3'd0, 16'h1111, 6'd1, 6'd0, 17'h0},
    '{3'd0, 16'h2222, 6'd2, 6'd0, 17'h0},
    '{3'd1, 16'h3333, 6'd2, 6'd0, 17'h0},
    '{3'd2, 16'h0000, 6'd1, 6'd0, 17'h11111},
    '{3'd0, 16'h4444, 6'd2, 6'd0, 17'h0},
    '{3'd2, 16'h0000, 6'd1, 6'd0, 17'h12222},
    '{3'd2, 16'h0000, 6'd0, 6'd0, 17'h14444},
    '{3'd3, 16'hAAAA, 6'd0, 6'd1, 17'h0},
    '{3'd3, 16'hBBBB, 6'd0, 6'd2, 17'h0},
    '{3'd4, 16'h0000, 6'd0, 6'd1, 17'h1AAAA},
    '{3'd4, 16'h0000, 6'd0, 6'd0, 17'h1BBBB}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input int op, input logic [15:0] d);
    @(negedge clk);
    case (op)
      0: begin bus_tx_wr = 1'b1; bus_tx_wdata = {1'b1, d}; end
      1: begin bus_tx_wr = 1'b1; bus_tx_wdata = {1'b0, d}; end
      2: ser_tx_pull = 1'b1;
      3: begin ser_rx_push = 1'b1; ser_rx_data = d; end
      default: bus_rx_rd = 1'b1;
    endcase
    @(negedge clk);
    bus_tx_wr = 1'b0; ser_tx_pull = 1'b0; ser_rx_push = 1'b0; bus_rx_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ctl_enable = 1; tx_queue_en = 1; rx_queue_en = 1; tx_dma_en = 1; rx_dma_en = 1;
    tx_thresh = 6'd4; rx_thresh = 6'd32;
    irq_global_en = 0; irq_src_en = '0; irq_clr = 0;
    bus_tx_wr = 0; bus_tx_wdata = '0; bus_rx_rd = 0; ser_tx_pull = 0;
    ser_rx_push = 0; ser_rx_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state (R5, R6, R7, R10)
    chk(tx_count, 0, "R5 reset tx_count");
    chk(rx_count, 0, "R5 reset rx_count");
    chk(irq_status, 12'h0C3, "R10 reset status");
    chk(irq_pending, 0, "R10 reset pending");
    chk(tx_dma_req, 1, "R6 reset tx dma");
    chk(rx_dma_req, 0, "R7 reset rx dma");

    // vector table: R1 R2 R3
    foreach (VECS[i]) begin
      do_op(int'(VECS[i].op), VECS[i].data);
      chk(tx_count, VECS[i].txc, "R1 R2 table tx_count");
      chk(rx_count, VECS[i].rxc, "R3 table rx_count");
      if (VECS[i].op == 3'd2) chk({ser_tx_valid, ser_tx_data}, VECS[i].exp, "R2 table pull");
      if (VECS[i].op == 3'd4) chk(bus_rx_rdata, VECS[i].exp, "R3 table read");
    end

    // R8 underrun
    do_op(2, 16'h0);
    chk({ser_tx_valid, ser_tx_data}, 0, "R8 underrun data");
    chk(irq_status[10], 1, "R8 tx starve sticky");
    chk(tx_count, 0, "R8 count stays");
    // R3 empty read
    do_op(4, 16'h0);
    chk(bus_rx_rdata, 0, "R3 empty read");
    chk(irq_status[4], 1, "R3 rx starve sticky");

    // R10 masked
    @(negedge clk); irq_src_en = 12'hFFF;
    repeat (2) @(negedge clk);
    chk(irq_pending, 0, "R10 global mask");
    irq_src_en = 12'h400; irq_global_en = 1;
    @(negedge clk);
    chk(irq_pending, 1, "R10 pending from tx starve");
    // R11 clear of sticky source
    pulse_clr();
    chk(irq_pending, 0, "R11 pending cleared");
    chk(irq_status[10], 0, "R11 tx starve cleared");
    chk(irq_status[4], 0, "R11 rx starve cleared");
    @(negedge clk);
    chk(irq_pending, 0, "R11 stays clear");
    // R11 level source returns
    irq_src_en = 12'h040;
    @(negedge clk);
    chk(irq_pending, 1, "R10 tx empty pending");
    pulse_clr();
    chk(irq_pending, 0, "R11 clear edge");
    @(negedge clk);
    chk(irq_pending, 1, "R11 level reasserts");
    irq_src_en = '0;
    pulse_clr();
    @(negedge clk);
    chk(irq_pending, 0, "R10 masked after clear");

    // fill tx: R5 R6 R9
    for (int i = 0; i < 32; i++) begin
      do_op(0, 16'h0100 + 16'(i));
      if (i == 2) chk(tx_dma_req, 1, "R6 below threshold");
      if (i == 3) begin
        chk(tx_dma_req, 0, "R6 at threshold");
        chk(irq_status[7], 1, "R5 almost-empty at 4");
      end
      if (i == 4) chk(irq_status[7], 0, "R5 almost-empty off at 5");
      if (i == 26) chk(irq_status[9], 0, "R5 almost-full off at 27");
      if (i == 27) chk(irq_status[9], 1, "R5 almost-full at 28");
    end
    chk(tx_count, 32, "R5 tx count full");
    chk(irq_status[8], 1, "R5 tx full flag");
    do_op(0, 16'hDEAD);
    chk(tx_count, 32, "R9 tx overflow count");
    chk(irq_status[11], 1, "R9 tx overflow sticky");
    do_op(2, 16'h0);
    chk({ser_tx_valid, ser_tx_data}, 17'h10100, "R2 oldest after fill");
    chk(tx_count, 31, "R2 count after pull");

    // R4 gating
    @(negedge clk); ctl_enable = 0;
    do_op(2, 16'h0);
    chk(tx_count, 31, "R4 pull halted");
    chk(ser_tx_valid, 0, "R4 no sample");
    do_op(3, 16'h5555);
    chk(rx_count, 0, "R4 push halted");
    chk(tx_dma_req, 0, "R6 inactive no dma");
    @(negedge clk); ctl_enable = 1; tx_queue_en = 0;
    do_op(0, 16'h6666);
    chk(tx_count, 31, "R4 tx queue disabled");
    @(negedge clk); tx_queue_en = 1;
    for (int i = 1; i < 32; i++) begin
      do_op(2, 16'h0);
      if (i == 31) chk({ser_tx_valid, ser_tx_data}, 17'h1011F, "R2 last in order");
    end
    chk(tx_count, 0, "R2 drained");

    // rx fill: R7 R9
    for (int i = 0; i < 32; i++) begin
      do_op(3, 16'h0200 + 16'(i));
      if (i == 30) chk(rx_dma_req, 0, "R7 below threshold");
    end
    chk(rx_dma_req, 1, "R7 at threshold");
    chk(irq_status[2], 1, "R5 rx full flag");
    @(negedge clk); rx_dma_en = 0;
    @(negedge clk);
    chk(rx_dma_req, 0, "R7 dma disabled");
    rx_dma_en = 1;
    do_op(3, 16'hDEAD);
    chk(rx_count, 32, "R9 drop keeps count");
    chk(irq_status[5], 1, "R9 rx overflow sticky");
    do_op(4, 16'h0);
    chk(bus_rx_rdata, 17'h10200, "R3 oldest rx");
    chk(rx_dma_req, 0, "R7 falls below");
    for (int i = 1; i < 32; i++) begin
      do_op(4, 16'h0);
      if (i == 31) chk(bus_rx_rdata, 17'h1021F, "R9 dropped sample absent");
    end
    do_op(4, 16'h0);
    chk(bus_rx_rdata, 0, "R3 empty after drain");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule